// File: doc/BRIEF.md
# Serial LED Sink Driver Logic

This block is the digital core of a twelve-channel LED sink driver. A host shifts channel data in one bit at a time on a shift clock, then copies the whole word into a holding register with a separate latch clock. The holding register drives one enable line per channel. Each line tells the matching open-drain sink to conduct. An active-low output enable gates every channel at once, so it can serve as a global PWM dimming input without disturbing the held word.

Both clocks arrive as ordinary signals and are sampled in a faster system clock domain. Their edges are found by comparing each sample with the previous one. A cascade output presents the last shift stage to the next device in a chain. It is updated on the falling edge of the shift clock, so the downstream device always has half a period of hold time. An active-low clear wipes all data registers at once, without waiting for a clock.

A junction-temperature code, an unsigned value in degrees Celsius, feeds a thermal guard with hysteresis. While the guard is tripped, every channel is forced off.

Top module: `led_sink_core`

## Requirements
- R1: A rising edge on `sclk_in` shifts `ser_in` into stage 0 and moves stage i into stage i+1. The edge is acted on at the first system clock edge that sees `sclk_in` high after it was low. After 12 shifts, the first bit sent sits in stage 11. Channel i is fed from stage i.
- R2: A rising edge on `lclk_in` copies all 12 shift stages into the holding register in parallel. Shifting alone never changes `sink_on`.
- R3: While `clr_n` is low, the shift stages, the holding register and the cascade register are zero. The clear takes effect at once, without a system clock edge.
- R4: While `oe_n` is high, `sink_on` is all zeros, whatever the holding register contains.
- R5: While `oe_n` is low and the guard is not tripped, `sink_on` equals the holding register. Toggling `oe_n` leaves the held word unchanged.
- R6: `ser_out` carries stage 11. It changes only at a falling edge of `sclk_in`, so a new top bit stays hidden until the shift clock returns low.
- R7: The thermal guard trips when `temp_c` is above 175. It releases when `temp_c` is below 160, and it keeps its state for values from 160 to 175. While it is tripped, `sink_on` is all zeros.
- R8: While `rst_n` is low at a system clock edge, all registers are cleared, including the edge history and the thermal guard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample both external clocks |
| rst_n | input | 1 | Synchronous active-low system reset |
| clr_n | input | 1 | Asynchronous active-low clear of the data registers |
| sclk_in | input | 1 | Shift clock, sampled |
| lclk_in | input | 1 | Latch clock, sampled |
| ser_in | input | 1 | Serial data input |
| oe_n | input | 1 | Active-low output enable (PWM dimming) |
| temp_c | input | 8 | Junction temperature in degrees Celsius, unsigned |
| sink_on | output | 12 | Per-channel sink enable, 1 = conduct |
| ser_out | output | 1 | Cascade serial output |

## Verification
The bench walks temperatures up and down through both thresholds and sits on the exact boundary values 175 and 160. A guard without hysteresis would re-enable the outputs at 170 on the way down, and an off-by-one compare would trip at 175 itself. It checks `ser_out` after the twelfth rising edge but before the falling edge. A design that retimed on the rising edge would show the first bit one half-period too early, and one that dropped the retime would show it as soon as the shift happens. The bench also checks `sink_on` right after `clr_n` falls, with no clock edge in between, which catches a clear that waits for a clock edge. Finally, it checks that shifting without a latch edge leaves the outputs unchanged and that toggling `oe_n` gives back the same word.

// File: rtl/led_sink_pkg.sv
// Package: shared sizing and thermal thresholds for the LED sink driver core.
// Assumes temperature codes are unsigned whole degrees Celsius.
package led_sink_pkg;
    localparam int CHANNELS   = 12;
    localparam int TEMP_BITS  = 8;
    localparam int TRIP_HOT   = 175;
    localparam int TRIP_COOL  = 160;
endpackage

// File: rtl/led_edge_detect.sv
// Module: finds rising and falling edges of a slow signal sampled in clk.
// Assumes the input is already synchronous to clk (driven by same-domain logic).
module led_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic prev_q;

    // Purpose: remember the value seen at the previous system clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= din;
    end

    assign rise = din & ~prev_q;
    assign fall = ~din & prev_q;
endmodule

// File: rtl/led_shift_chain.sv
// Module: serial-in shift register with a cascade output retimed to the
// falling shift-clock edge. Assumes rise and fall are single-cycle pulses.
module led_shift_chain #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             shift_rise,
    input  logic             shift_fall,
    input  logic             ser_in,
    output logic [WIDTH-1:0] stages,
    output logic             ser_out
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] stage_q;
    logic             casc_q;

    // Purpose: shift one bit in per rising shift edge; async clear wins.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)          stage_q <= '0;
        else if (!rst_n)     stage_q <= '0;
        else if (shift_rise) stage_q <= {stage_q[TOP-1:0], ser_in};
    end

    // Purpose: present the top stage downstream only on the falling edge.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)          casc_q <= 1'b0;
        else if (!rst_n)     casc_q <= 1'b0;
        else if (shift_fall) casc_q <= stage_q[TOP];
    end

    assign stages  = stage_q;
    assign ser_out = casc_q;
endmodule

// File: rtl/led_thermal_guard.sv
// Module: thermal shutdown flag with hysteresis.
// Assumes HOT > COOL; codes between them hold the previous state.
module led_thermal_guard #(
    parameter int TW   = 8,
    parameter int HOT  = 175,
    parameter int COOL = 160
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp_c,
    output logic          tripped
);
    localparam logic [TW-1:0] HOT_T  = TW'(HOT);
    localparam logic [TW-1:0] COOL_T = TW'(COOL);

    logic trip_q;

    // Purpose: set above the hot limit, clear below the cool limit, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)               trip_q <= 1'b0;
        else if (temp_c > HOT_T)  trip_q <= 1'b1;
        else if (temp_c < COOL_T) trip_q <= 1'b0;
    end

    assign tripped = trip_q;
endmodule

// File: rtl/led_sink_core.sv
// Module: top of the LED sink driver core: edge detection, shift chain,
// holding register, output gating and thermal guard.
// Assumes sclk_in and lclk_in change no faster than every other clk cycle.
module led_sink_core
    import led_sink_pkg::*;
#(
    parameter int CH    = CHANNELS,
    parameter int TW    = TEMP_BITS,
    parameter int HOT   = TRIP_HOT,
    parameter int COOL  = TRIP_COOL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_n,
    input  logic          sclk_in,
    input  logic          lclk_in,
    input  logic          ser_in,
    input  logic          oe_n,
    input  logic [TW-1:0] temp_c,
    output logic [CH-1:0] sink_on,
    output logic          ser_out
);
    localparam int NCLK = 2;   // shift clock, latch clock

    logic [NCLK-1:0] clk_raw, clk_rise, clk_fall;
    logic [CH-1:0]   stages;
    logic [CH-1:0]   store_q;
    logic            hot;

    assign clk_raw = {lclk_in, sclk_in};

    // Purpose: one edge detector per sampled external clock.
    for (genvar g = 0; g < NCLK; g++) begin : g_edge
        led_edge_detect u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (clk_raw[g]),
            .rise (clk_rise[g]),
            .fall (clk_fall[g])
        );
    end

    led_shift_chain #(.WIDTH(CH)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .shift_rise(clk_rise[0]),
        .shift_fall(clk_fall[0]),
        .ser_in    (ser_in),
        .stages    (stages),
        .ser_out   (ser_out)
    );

    led_thermal_guard #(.TW(TW), .HOT(HOT), .COOL(COOL)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .temp_c (temp_c),
        .tripped(hot)
    );

    // Purpose: copy the shift stages into the holding register on a latch edge.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)           store_q <= '0;
        else if (!rst_n)      store_q <= '0;
        else if (clk_rise[1]) store_q <= stages;
    end

    // Purpose: gate the held word by output enable and the thermal guard.
    always_comb begin
        if (oe_n || hot) sink_on = '0;
        else             sink_on = store_q;
    end
endmodule

// File: rtl/led_sink_checker.sv
// Module: assertion checker bound to led_sink_core.
// Assumes it is attached through the bind below.
module led_sink_checker #(
    parameter int CH   = 12,
    parameter int TW   = 8,
    parameter int HOT  = 175
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr_n,
    input logic          oe_n,
    input logic          sclk_in,
    input logic [TW-1:0] temp_c,
    input logic [CH-1:0] sink_on,
    input logic [CH-1:0] store_q,
    input logic          ser_out
);
    localparam logic [TW-1:0] HOT_T = TW'(HOT);

    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (sink_on == '0 && ser_out == 1'b0 && store_q == '0));

    assert_oe_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> sink_on == '0);

    assert_hot_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_c > HOT_T) |=> sink_on == '0);

    assert_cascade_fall_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ser_out) && clr_n && $past(clr_n) && $past(rst_n))
            |-> ($past(sclk_in, 2) && !$past(sclk_in, 1)));

    assert_out_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sink_on & ~store_q) == '0);
endmodule

bind led_sink_core led_sink_checker #(.CH(CH), .TW(TW), .HOT(HOT)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_n  (clr_n),
    .oe_n   (oe_n),
    .sclk_in(sclk_in),
    .temp_c (temp_c),
    .sink_on(sink_on),
    .store_q(store_q),
    .ser_out(ser_out)
);

// File: tb/test_led_sink_core.sv
module test_led_sink_core;
    localparam int CH = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_n = 1'b1;
    logic          sclk_in = 1'b0;
    logic          lclk_in = 1'b0;
    logic          ser_in = 1'b0;
    logic          oe_n = 1'b1;
    logic [7:0]    temp_c = 8'd25;
    logic [CH-1:0] sink_on;
    logic          ser_out;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [CH-1:0] WORD_A = 12'hA5C;
    localparam logic [CH-1:0] WORD_B = 12'h3C1;

    // {temperature, expected outputs enabled}, walked in order (R7)
    localparam logic [8:0] THERM_TAB [0:9] = '{
        {8'd25,  1'b1}, {8'd175, 1'b1}, {8'd176, 1'b0}, {8'd170, 1'b0},
        {8'd160, 1'b0}, {8'd159, 1'b1}, {8'd170, 1'b1}, {8'd175, 1'b1},
        {8'd220, 1'b0}, {8'd100, 1'b1}
    };

    always #10 clk = ~clk;

    led_sink_core i_led_sink_core (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sclk_in(sclk_in),
        .lclk_in(lclk_in), .ser_in(ser_in), .oe_n(oe_n), .temp_c(temp_c),
        .sink_on(sink_on), .ser_out(ser_out)
    );

    task automatic check(input string req, input logic [CH-1:0] act, input logic [CH-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk); ser_in = b; sclk_in = 1'b1;
        @(negedge clk); sclk_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_word(input logic [CH-1:0] w);
        for (int i = CH - 1; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic latch_pulse();
        @(negedge clk); lclk_in = 1'b1;
        @(negedge clk); lclk_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset sink_on", sink_on, '0);
        check("R8 reset ser_out", {11'd0, ser_out}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: shifting alone does not reach the outputs
        oe_n = 1'b0;
        load_word(WORD_A);
        check("R2 no latch yet", sink_on, '0);
        latch_pulse();
        check("R1 R2 word latched", sink_on, WORD_A);

        // R7: thermal table walk with hysteresis
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); temp_c = THERM_TAB[k][8:1];
            @(negedge clk);
            check($sformatf("R7 temp %0d", THERM_TAB[k][8:1]), sink_on,
                  THERM_TAB[k][0] ? WORD_A : '0);
        end
        temp_c = 8'd25;
        @(negedge clk);

        // R4/R5: output enable gating as PWM, held word intact
        oe_n = 1'b1; @(negedge clk);
        check("R4 oe high off", sink_on, '0);
        oe_n = 1'b0; @(negedge clk);
        check("R5 oe low restores", sink_on, WORD_A);

        // R2: new word replaces old only at latch
        load_word(WORD_B);
        check("R2 old word held", sink_on, WORD_A);
        latch_pulse();
        check("R2 new word", sink_on, WORD_B);

        // R3: asynchronous clear, checked before any clock edge
        @(negedge clk); clr_n = 1'b0; #1;
        check("R3 async clear", sink_on, '0);
        @(negedge clk); clr_n = 1'b1;
        latch_pulse();
        check("R3 shift stages cleared", sink_on, '0);

        // R6: cascade output of first bit after 12 rises plus one fall
        shift_bit(1'b1);
        for (int i = 0; i < 10; i++) shift_bit(1'b0);
        check("R6 before 12th shift", {11'd0, ser_out}, '0);
        @(negedge clk); ser_in = 1'b0; sclk_in = 1'b1;
        @(negedge clk);
        check("R6 after rise, before fall", {11'd0, ser_out}, '0);
        sclk_in = 1'b0;
        @(negedge clk);
        check("R6 after fall", {11'd0, ser_out}, 12'd1);
        latch_pulse();
        check("R1 first bit in stage 11", sink_on, 12'h800);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule